// File: doc/BRIEF.md
# Transmit Inter-Packet Gap Controller

This block sits beside the transmit side of a 10G Ethernet MAC with a four-byte lane datapath. It watches the frame beats going to the line. After each frame it holds back the next start until enough idle octets have passed. A single output, `tx_permit_o`, tells the frame source in which cycle a new frame may begin. Every frame starts on lane 0.

There are two gap modes, and the mode input picks one at run time.

- **LAN mode.** The configuration field is an octet count in steps of four. The recommended setting is 12. The gap is kept aligned to lane 0 with a deficit idle count. Each individual gap may be up to three octets shorter or longer than the setting, but the running average stays on the setting.
- **WAN mode.** The same field is a stretch value. The block counts the octets it sends. For every full stretch ratio of octets, it adds one idle octet on top of a fixed base gap. A larger stretch value therefore means a shorter average gap and more bandwidth.

When transmit is disabled, no new frame may start. A frame that is already in flight still finishes, and its gap and deficit are still accounted for.

Top module: `ipg_gap_ctrl`

## Requirements
- R1: After reset, the deficit is zero, the WAN octet accumulator is empty and no frame is in progress. `tx_permit_o` is high in the first cycle after reset in which `tx_en_i` is high.
- R2: In LAN mode, the 10-bit `ipg_cfg_i` value is rounded up to the next multiple of 4 and then clamped to the range 8..100. This gives the gap G in octets; for example, 13 gives 16, 3 gives 8, and 1023 gives 100.
- R3: A beat with `beat_i`=1 and `last_i`=0 opens a frame, and the frame stays open until a beat with `last_i`=1. While a frame is open, `tx_permit_o` is low.
- R4: Suppose a final beat (`beat_i`=1, `last_i`=1, `last_lane_i`=L, where L is the index 0..3 of the last valid byte and lane 0 carries the first byte) occurs in cycle t. Then `tx_permit_o` is low in cycles t+1..t+n and high in cycle t+n+1 while `tx_en_i`=1. The idle octets spent are (3-L)+4n.
- R5: Let need = G-(3-L) and m = need mod 4, with deficit d. If d+m<=3, then n=floor(need/4) and d becomes d+m. Otherwise n=floor(need/4)+1 and d becomes d+m-4. The deficit never leaves 0..3, and each gap lies within G-3..G+3 octets.
- R6: In LAN mode, at every legal setting, the idle octets summed over any run of k frames differ from G*k by at most 3.
- R7: In WAN mode, the 10-bit `ipg_cfg_i` value is clamped to 4..15. The stretch ratio is (value+1)*8, so 12 gives 104.
- R8: In WAN mode, every octet of every beat is counted (four per beat, L+1 on a final beat). Each time the count reaches the ratio, one idle octet is owed and the ratio is subtracted from the count. At the end of a frame, G = 12 plus the owed octets, which are then cleared. The R5 alignment applies to this G. The accumulator is cleared in any cycle where `wan_mode_i`=0.
- R9: In WAN mode, a larger stretch value gives fewer idle octets over the same traffic.
- R10: While `tx_en_i`=0, `tx_permit_o` is low. A frame already open still completes, and its gap and deficit accounting proceed as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; low blocks new frame starts |
| wan_mode_i | input | 1 | 1 selects WAN stretch mode, 0 selects LAN octet gap |
| ipg_cfg_i | input | 10 | Gap setting: octet count in LAN mode, stretch value in WAN mode |
| beat_i | input | 1 | A four-lane frame beat is sent in this cycle |
| last_i | input | 1 | This beat is the final beat of its frame |
| last_lane_i | input | 2 | Lane of the last valid byte on a final beat |
| tx_permit_o | output | 1 | A new frame may start in this cycle |

## Verification
The bench ends frames on all four lanes, in patterns that walk the deficit through every value and force both the shorten branch and the extend branch.

- A design that ignored the deficit, or let it leave 0..3, would drift off the average gap.
- A design that let the deficit overflow would produce a gap outside G±3.

Settings that are unaligned or out of range check the rounding and clamping. A design that truncated instead of rounding up would give gaps four octets short.

In WAN mode, long frames at several stretch values test that owed octets accumulate across beats and are cleared at each frame end. The bench also compares a small stretch value against a large one, so a reversed ratio would show as the wrong ordering.

A final case drops transmit enable in the middle of a frame. A design that aborted the frame, lost its deficit, or granted permission while disabled would miss the expected gaps that follow.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int LANE_BYTES = 4;
  localparam int LANE_W     = $clog2(LANE_BYTES);

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic {
    MODE_LAN = 1'b0,
    MODE_WAN = 1'b1
  } gap_mode_e;
endpackage

// File: rtl/ipg_cfg_decode.sv
module ipg_cfg_decode #(
  parameter int CFG_W   = 10,
  parameter int GAP_W   = 10,
  parameter int RATIO_W = 8,
  parameter int LAN_MIN = 8,
  parameter int LAN_MAX = 100,
  parameter int WAN_MIN = 4,
  parameter int WAN_MAX = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CFG_W-1:0]   cfg_i,
  output logic [GAP_W-1:0]   lan_gap_o,
  output logic [RATIO_W-1:0] wan_ratio_o
);
  localparam int RND_W = CFG_W + 1;

  logic [RND_W-1:0] rnd;
  logic [CFG_W-1:0] wsel;

  // round up to a multiple of four, then clamp
  assign rnd = ({1'b0, cfg_i} + RND_W'(3)) & ~RND_W'(3);

  always_comb begin
    if (rnd < RND_W'(LAN_MIN))      lan_gap_o = GAP_W'(LAN_MIN);
    else if (rnd > RND_W'(LAN_MAX)) lan_gap_o = GAP_W'(LAN_MAX);
    else                            lan_gap_o = GAP_W'(rnd);
  end

  always_comb begin
    if (cfg_i < CFG_W'(WAN_MIN))      wsel = CFG_W'(WAN_MIN);
    else if (cfg_i > CFG_W'(WAN_MAX)) wsel = CFG_W'(WAN_MAX);
    else                              wsel = cfg_i;
  end

  assign wan_ratio_o = RATIO_W'((wsel + CFG_W'(1)) << 3);

  AST_LAN_GAP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lan_gap_o >= GAP_W'(LAN_MIN)) && (lan_gap_o <= GAP_W'(LAN_MAX)) && (lan_gap_o[1:0] == 2'b00)); // R2
  AST_WAN_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wan_ratio_o >= RATIO_W'((WAN_MIN + 1) * 8)) && (wan_ratio_o <= RATIO_W'((WAN_MAX + 1) * 8))
    && (wan_ratio_o[2:0] == 3'b000)); // R7
endmodule

// File: rtl/ipg_wan_stretch.sv
module ipg_wan_stretch #(
  parameter int RATIO_W = 8,
  parameter int OWED_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wan_en_i,
  input  logic               beat_i,
  input  logic               eof_i,
  input  logic [2:0]         bytes_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [OWED_W-1:0]  owed_o
);
  localparam int SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] acc_q, acc_n;
  logic [OWED_W-1:0]  owed_q;
  logic [SUM_W-1:0]   sum;
  logic               wrap;

  assign sum  = {1'b0, acc_q} + SUM_W'(bytes_i);
  assign wrap = wan_en_i && beat_i && (sum >= {1'b0, ratio_i});
  assign acc_n = wrap ? RATIO_W'(sum - {1'b0, ratio_i}) : RATIO_W'(sum);
  // saturating owed count, includes this beat's wrap
  assign owed_o = (wrap && (owed_q != '1)) ? owed_q + OWED_W'(1) : owed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      owed_q <= '0;
    end else if (!wan_en_i) begin
      acc_q  <= '0;
      owed_q <= '0;
    end else if (beat_i) begin
      acc_q  <= acc_n;
      owed_q <= eof_i ? '0 : owed_o;
    end
  end

  AST_OWED_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && eof_i) |=> (owed_q == '0)); // R8
  AST_LAN_ACC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wan_en_i |=> (acc_q == '0)); // R8
endmodule

// File: rtl/ipg_dic_align.sv
module ipg_dic_align
  import ipg_pkg::*;
#(
  parameter int GAP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eof_i,
  input  lane_t            last_lane_i,
  input  logic [GAP_W-1:0] gap_octets_i,
  output logic [GAP_W-1:0] idle_beats_o
);
  localparam int NEED_W = GAP_W + 1;
  localparam int TOT_W  = GAP_W + 3;

  logic [1:0]        dic_q;
  logic [NEED_W-1:0] need;
  logic [1:0]        rem;
  logic [2:0]        dsum;
  logic              fits;
  logic [TOT_W-1:0]  idle_bytes;

  // octets still owed after the tail lanes of the final beat
  assign need = {1'b0, gap_octets_i} - NEED_W'(lane_t'(LANE_BYTES - 1) - last_lane_i);
  assign rem  = need[1:0];
  assign dsum = {1'b0, dic_q} + {1'b0, rem};
  assign fits = !dsum[2];
  assign idle_beats_o = GAP_W'(need >> 2) + (fits ? GAP_W'(0) : GAP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dic_q <= 2'd0;
    else if (eof_i) dic_q <= dsum[1:0];
  end

  assign idle_bytes = TOT_W'(lane_t'(LANE_BYTES - 1) - last_lane_i) + (TOT_W'(idle_beats_o) << 2);

  AST_GAP_WITHIN_DIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |-> ((idle_bytes + TOT_W'(3) >= TOT_W'(gap_octets_i)) &&
               (idle_bytes <= TOT_W'(gap_octets_i) + TOT_W'(3)))); // R5
endmodule

// File: rtl/ipg_gap_ctrl.sv
module ipg_gap_ctrl
  import ipg_pkg::*;
#(
  parameter int CFG_W        = 10,
  parameter int GAP_W        = 10,
  parameter int RATIO_W      = 8,
  parameter int OWED_W       = 8,
  parameter int WAN_BASE_GAP = 12,
  parameter int LAN_MIN      = 8,
  parameter int LAN_MAX      = 100,
  parameter int WAN_MIN      = 4,
  parameter int WAN_MAX      = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             wan_mode_i,
  input  logic [CFG_W-1:0] ipg_cfg_i,
  input  logic             beat_i,
  input  logic             last_i,
  input  logic [1:0]       last_lane_i,
  output logic             tx_permit_o
);
  gap_mode_e          mode;
  logic [GAP_W-1:0]   lan_gap, gap_octets, idle_beats, gap_q;
  logic [RATIO_W-1:0] wan_ratio;
  logic [OWED_W-1:0]  owed;
  logic [2:0]         beat_bytes;
  logic               in_frame_q, eof;

  assign mode       = wan_mode_i ? MODE_WAN : MODE_LAN;
  assign eof        = beat_i && last_i;
  assign beat_bytes = last_i ? ({1'b0, last_lane_i} + 3'd1) : 3'(LANE_BYTES);

  ipg_cfg_decode #(
    .CFG_W(CFG_W), .GAP_W(GAP_W), .RATIO_W(RATIO_W),
    .LAN_MIN(LAN_MIN), .LAN_MAX(LAN_MAX), .WAN_MIN(WAN_MIN), .WAN_MAX(WAN_MAX)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(ipg_cfg_i),
    .lan_gap_o(lan_gap), .wan_ratio_o(wan_ratio)
  );

  ipg_wan_stretch #(.RATIO_W(RATIO_W), .OWED_W(OWED_W)) u_stretch (
    .clk_i(clk_i), .rst_ni(rst_ni), .wan_en_i(mode == MODE_WAN),
    .beat_i(beat_i), .eof_i(eof), .bytes_i(beat_bytes),
    .ratio_i(wan_ratio), .owed_o(owed)
  );

  assign gap_octets = (mode == MODE_WAN) ? GAP_W'(WAN_BASE_GAP) + GAP_W'(owed) : lan_gap;

  ipg_dic_align #(.GAP_W(GAP_W)) u_dic (
    .clk_i(clk_i), .rst_ni(rst_ni), .eof_i(eof), .last_lane_i(last_lane_i),
    .gap_octets_i(gap_octets), .idle_beats_o(idle_beats)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      gap_q      <= '0;
    end else begin
      if (beat_i) in_frame_q <= !last_i;
      if (eof)                 gap_q <= idle_beats;
      else if (gap_q != '0)    gap_q <= gap_q - GAP_W'(1);
    end
  end

  assign tx_permit_o = tx_en_i && !in_frame_q && (gap_q == '0);

  AST_GAP_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof |=> !tx_permit_o); // R4
  AST_GAP_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gap_q > GAP_W'(1)) && !eof) |=> !tx_permit_o); // R4
  AST_BODY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !last_i) |=> !tx_permit_o); // R3
  AST_DISABLED_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !tx_permit_o); // R10
endmodule

// File: tb/sim_ipg_gap_ctrl.sv
module sim_ipg_gap_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       wan = 1'b0;
  logic [9:0] cfg = 10'd12;
  logic       beat = 1'b0;
  logic       last = 1'b0;
  logic [1:0] lane = 2'd0;
  logic       permit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipg_gap_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .wan_mode_i(wan),
    .ipg_cfg_i(cfg), .beat_i(beat), .last_i(last), .last_lane_i(lane),
    .tx_permit_o(permit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model state
  int dic_m = 0;
  int acc_m = 0;

  function automatic int gap_of(input bit w, input int c, input int len);
    int v, r;
    if (!w) begin
      v = ((c + 3) / 4) * 4;
      if (v < 8) v = 8;
      if (v > 100) v = 100;
      acc_m = 0;
      return v;
    end
    v = c;
    if (v < 4) v = 4;
    if (v > 15) v = 15;
    r = (v + 1) * 8;
    acc_m += len;
    v = acc_m / r;
    acc_m = acc_m % r;
    return 12 + v;
  endfunction

  function automatic int model(input bit w, input int c, input int len);
    int g, l, need, nf, m;
    g = gap_of(w, c, len);
    l = (len - 1) % 4;
    need = g - (3 - l);
    nf = need / 4;
    m = need % 4;
    if (dic_m + m <= 3) begin
      dic_m += m;
      return nf;
    end
    dic_m = dic_m + m - 4;
    return nf + 1;
  endfunction

  // scoreboard
  int    exp_q[$];
  string tag_q[$];
  bit    mon_skip = 0;
  bit    counting = 0;
  bit    in_body = 0;
  int    cnt = 0;
  int    cap_lane = 0;
  int    idle_meas = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_body) chk(!permit, "R3 permit during frame", int'(permit), 0);
      if (counting) begin
        if (!permit) cnt++;
        else begin
          counting = 0;
          if (!mon_skip) begin
            idle_meas += (3 - cap_lane) + 4 * cnt;
            if (exp_q.size() == 0) chk(0, "R4 unexpected gap", cnt, -1);
            else begin
              int e;
              string t;
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              chk(cnt == e, t, cnt, e);
            end
          end
        end
      end
      if (beat && last) begin
        counting = 1;
        cnt = 0;
        cap_lane = int'(lane);
        in_body = 0;
      end else if (beat) in_body = 1;
    end
  end

  task automatic wait_permit();
    while (!permit) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input int len, input string tag);
    int nb;
    nb = (len + 3) / 4;
    exp_q.push_back(model(wan, int'(cfg), len));
    tag_q.push_back(tag);
    wait_permit();
    for (int i = 0; i < nb; i++) begin
      beat = 1'b1;
      last = (i == nb - 1);
      lane = 2'((len - 1) % 4);
      @(posedge clk);
      #1;
    end
    beat = 1'b0;
    last = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || counting) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wan_restart();
    wan = 1'b0;
    @(posedge clk);
    #1;
    wan = 1'b1;
    acc_m = 0;
  endtask

  task automatic run_avg(input int c);
    int g, d;
    drain();
    cfg = 10'(c);
    g = ((c + 3) / 4) * 4;
    idle_meas = 0;
    foreach (lens_avg[i]) send_frame(lens_avg[i], "R5 LAN gap");
    drain();
    d = idle_meas - g * 8;
    chk(d >= -3 && d <= 3, "R6 average gap", idle_meas, g * 8);
  endtask

  int lens_avg[8] = '{61, 62, 63, 64, 65, 66, 67, 70};
  int lens_a[12] = '{64, 65, 66, 67, 64, 65, 65, 65, 65, 100, 61, 63};

  initial begin
    int sa, sb, bad;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(permit == 1'b0, "R10 idle disabled after reset", int'(permit), 0);
    @(posedge clk);
    #1;
    tx_en = 1'b1;
    #1;
    chk(permit == 1'b1, "R1 permit after reset", int'(permit), 1);

    // R4 R5: default setting, all end lanes
    foreach (lens_a[i]) send_frame(lens_a[i], "R4 gap cycles");
    for (int i = 1; i <= 9; i++) send_frame(i, "R5 short frames");

    // R6: legal settings
    run_avg(8);
    run_avg(12);
    run_avg(16);
    run_avg(52);
    run_avg(100);

    // R2: rounding and clamping
    drain();
    cfg = 10'd13;   send_frame(66, "R2 cfg 13");
    cfg = 10'd3;    send_frame(67, "R2 cfg 3");
    cfg = 10'd1023; send_frame(65, "R2 cfg 1023");
    cfg = 10'd98;   send_frame(64, "R2 cfg 98");
    cfg = 10'd0;    send_frame(62, "R2 cfg 0");

    // R7 R8: WAN stretch
    drain();
    cfg = 10'd12;
    wan_restart();
    for (int i = 0; i < 6; i++) send_frame(200 + i, "R8 WAN ratio 104");
    drain();
    cfg = 10'd2;
    wan_restart();
    for (int i = 0; i < 4; i++) send_frame(150 + 3 * i, "R7 WAN clamp low");
    drain();
    cfg = 10'd200;
    wan_restart();
    for (int i = 0; i < 4; i++) send_frame(333, "R7 WAN clamp high");

    // R9: small vs large stretch
    drain();
    cfg = 10'd4;
    wan_restart();
    idle_meas = 0;
    for (int i = 0; i < 5; i++) send_frame(300, "R8 WAN ratio 40");
    drain();
    sa = idle_meas;
    cfg = 10'd15;
    wan_restart();
    idle_meas = 0;
    for (int i = 0; i < 5; i++) send_frame(300, "R8 WAN ratio 128");
    drain();
    sb = idle_meas;
    chk(sa > sb, "R9 stretch ordering", sa, sb);

    // R10: disable mid-frame
    drain();
    wan = 1'b0;
    cfg = 10'd12;
    @(posedge clk);
    #1;
    wait_permit();
    mon_skip = 1;
    void'(model(1'b0, 12, 41));
    for (int i = 0; i < 11; i++) begin
      beat = 1'b1;
      last = (i == 10);
      lane = 2'd0;
      if (i == 3) tx_en = 1'b0;
      @(posedge clk);
      #1;
    end
    beat = 1'b0;
    last = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (permit) bad++;
    end
    chk(bad == 0, "R10 permit while disabled", bad, 0);
    @(posedge clk);
    #1;
    tx_en = 1'b1;
    #1;
    chk(permit == 1'b1, "R10 permit on re-enable", int'(permit), 1);
    @(negedge clk);
    @(posedge clk);
    #1;
    mon_skip = 0;
    for (int i = 0; i < 6; i++) send_frame(61 + i, "R10 deficit kept");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule